// File: doc/BRIEF.md
# Two-Wire Command Slave with Strap-Selected Address

This block is the serial control port of a larger device. It watches the two-wire bus (clock line and data line) using the system clock, recognises START and STOP conditions, and matches the first byte of each transfer against its own 7-bit address. A write transfer fills a command frame of one command byte followed by up to seven argument bytes. The frame is handed to the device core with a one-cycle strobe when the STOP arrives. A read transfer returns bytes from a response buffer of up to sixteen bytes that the core presents on a flat input bus.

The device address is not programmable. It is set by the level of a strap pin, which is sampled in the first clock cycle after reset is released. The data line is open-drain: the block only asserts an output enable, and that enable pulls the line low. Clock stretching and 10-bit addressing are not supported.

Top module: `i2c_cmd_slave`

## Requirements
- R1: Both bus lines pass through a two-stage synchronizer. A START (data falls while clock is high) starts a new address phase from any state, including in the middle of a transfer. A STOP (data rises while clock is high) returns the slave to idle with the data line released.
- R2: The first byte after a START is sampled on rising clock edges, MSB first. It carries the 7-bit address and then the direction bit (1 = read, 0 = write). On a match, the slave pulls the data line low from the falling edge after the eighth bit until the next falling edge.
- R3: If `addr_sel_i` is low when reset is released, the address is 7'h4A (1001010). If it is high, the address is 7'h1B (0011011). Changes on `addr_sel_i` after that have no effect until the next reset.
- R4: On an address mismatch the slave does not acknowledge. It keeps the data line released and ignores all traffic until the next START.
- R5: In a write, each data byte is acknowledged and stored. Byte k of the transfer (k = 0 is the command byte) appears on `cmd_data_o[8k+7:8k]`.
- R6: Written bytes after the eighth are not acknowledged and are dropped. The frame keeps the first eight bytes, and `cmd_len_o` never exceeds 8.
- R7: A STOP that ends an addressed write raises `cmd_valid_o` for exactly one cycle, with `cmd_len_o` equal to the number of stored bytes (0 to 8). Read transfers and non-matching transfers produce no strobe.
- R8: In a read, byte k comes from `rsp_data_i[8k+7:8k]`, sent MSB first. The data line changes only after falling clock edges.
- R9: When the master does not acknowledge a read byte, the slave releases the data line and sends nothing more until the next START (the master reads all ones).
- R10: A read returns at most 16 bytes. After the 16th byte the line is released even if the master acknowledged it.
- R11: A repeated START that interrupts a write discards the pending frame, so no strobe is raised for it.
- R12: During and directly after reset, `sda_oe_o` and `cmd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | When high, pulls the data line low |
| addr_sel_i | input | 1 | Strap pin that selects the address, sampled after reset |
| rsp_data_i | input | 8*RSP_MAX | Response bytes from the core; byte k at bits [8k+7:8k] |
| cmd_valid_o | output | 1 | One-cycle strobe when a write frame is complete |
| cmd_len_o | output | CMD_LW | Number of bytes in the delivered frame |
| cmd_data_o | output | 8*CMD_MAX | Command frame; byte k at bits [8k+7:8k] |

## Verification
The assertions assume a well-behaved master. The master changes the data line only while the clock is low, except when it issues a START or STOP. It never issues a START or STOP while the slave is driving an acknowledge or a data bit. It holds each clock phase for well over the three-cycle synchronizer and edge-detect latency.

Under these assumptions the slave's output enable can only toggle while the synchronized clock is low, and that is what the checks rely on. The bench master moves each line on the falling edge of the system clock. It holds every quarter bit for ten system cycles and samples the line in the middle of each high clock phase. This keeps every transfer within those assumptions.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic meta_q, sync_q;
    // idle bus level is high
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_boot_addr.sv
module i2c_boot_addr #(
  parameter logic [6:0] ADDR_PIN_LO = 7'h4A,
  parameter logic [6:0] ADDR_PIN_HI = 7'h1B
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       addr_sel_i,
  output logic [6:0] addr_o,
  output logic       done_o
);
  logic [6:0] addr_q;
  logic       done_q;

  // strap sampled once, first cycle out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= ADDR_PIN_HI;
      done_q <= 1'b0;
    end else if (!done_q) begin
      addr_q <= addr_sel_i ? ADDR_PIN_HI : ADDR_PIN_LO;
      done_q <= 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned CMD_MAX     = 8,
  parameter int unsigned RSP_MAX     = 16,
  parameter logic [6:0]  ADDR_PIN_LO = 7'h4A,
  parameter logic [6:0]  ADDR_PIN_HI = 7'h1B,
  localparam int unsigned CMD_LW     = $clog2(CMD_MAX + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic                 addr_sel_i,
  input  logic [8*RSP_MAX-1:0] rsp_data_i,
  output logic                 cmd_valid_o,
  output logic [CMD_LW-1:0]    cmd_len_o,
  output logic [8*CMD_MAX-1:0] cmd_data_o
);
  localparam int unsigned CMD_SEL = $clog2(CMD_MAX);
  localparam int unsigned RSP_IW  = $clog2(RSP_MAX + 1);
  localparam int unsigned RSP_SEL = $clog2(RSP_MAX);
  localparam logic [CMD_LW-1:0] CMD_LIM = CMD_LW'(CMD_MAX);
  localparam logic [RSP_IW-1:0] RSP_LIM = RSP_IW'(RSP_MAX);

  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] own_addr;
  logic       boot_done;

  i2c_line_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_bus_events u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_boot_addr #(
    .ADDR_PIN_LO(ADDR_PIN_LO),
    .ADDR_PIN_HI(ADDR_PIN_HI)
  ) u_boot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_sel_i(addr_sel_i),
    .addr_o    (own_addr),
    .done_o    (boot_done)
  );

  byte_t rsp_bytes [RSP_MAX];
  for (genvar g = 0; g < RSP_MAX; g++) begin : g_rsp
    assign rsp_bytes[g] = rsp_data_i[8*g +: 8];
  end

  slv_state_e        state_q;
  logic [3:0]        bit_cnt_q;
  byte_t             shreg_q;
  byte_t             tx_q;
  logic              rw_q;
  logic              oe_q;
  logic              mack_q;
  logic              wr_open_q;
  logic [CMD_LW-1:0] wr_cnt_q;
  logic [RSP_IW-1:0] rd_idx_q;
  logic              cmd_valid_q;
  logic [CMD_LW-1:0] cmd_len_q;
  byte_t             cmd_buf_q [CMD_MAX];
  byte_t             rsp_next;

  assign rsp_next = rsp_bytes[rd_idx_q[RSP_SEL-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      tx_q        <= '0;
      rw_q        <= 1'b0;
      oe_q        <= 1'b0;
      mack_q      <= 1'b0;
      wr_open_q   <= 1'b0;
      wr_cnt_q    <= '0;
      rd_idx_q    <= '0;
      cmd_valid_q <= 1'b0;
      cmd_len_q   <= '0;
      for (int i = 0; i < CMD_MAX; i++) cmd_buf_q[i] <= '0;
    end else begin
      cmd_valid_q <= 1'b0;
      if (start_det) begin
        // repeated start also drops any open write frame
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
        wr_open_q <= 1'b0;
        wr_cnt_q  <= '0;
      end else if (stop_det) begin
        state_q   <= ST_IDLE;
        oe_q      <= 1'b0;
        wr_open_q <= 1'b0;
        if (wr_open_q) begin
          cmd_valid_q <= 1'b1;
          cmd_len_q   <= wr_cnt_q;
        end
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise && bit_cnt_q != 4'd8) begin
              shreg_q   <= {shreg_q[6:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              if (shreg_q[7:1] == own_addr) begin
                oe_q    <= 1'b1;
                rw_q    <= shreg_q[0];
                state_q <= ST_AACK;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                tx_q      <= rsp_bytes[0];
                oe_q      <= ~rsp_bytes[0][7];
                bit_cnt_q <= 4'd1;
                rd_idx_q  <= '0;
                state_q   <= ST_RD;
              end else begin
                oe_q      <= 1'b0;
                bit_cnt_q <= '0;
                wr_open_q <= 1'b1;
                state_q   <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise && bit_cnt_q != 4'd8) begin
              shreg_q   <= {shreg_q[6:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              if (wr_cnt_q < CMD_LIM) begin
                cmd_buf_q[wr_cnt_q[CMD_SEL-1:0]] <= shreg_q;
                wr_cnt_q <= wr_cnt_q + CMD_LW'(1);
                oe_q     <= 1'b1;
              end else begin
                oe_q <= 1'b0;  // frame full: nack and drop
              end
              state_q <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bit_cnt_q != 4'd8) begin
                oe_q      <= ~tx_q[6];
                tx_q      <= {tx_q[6:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + 4'd1;
              end else begin
                oe_q     <= 1'b0;
                rd_idx_q <= rd_idx_q + RSP_IW'(1);
                state_q  <= ST_RACK;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q && rd_idx_q < RSP_LIM) begin
                tx_q      <= rsp_next;
                oe_q      <= ~rsp_next[7];
                bit_cnt_q <= 4'd1;
                state_q   <= ST_RD;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_IDLE;
              end
            end
          end
          default: begin
            oe_q    <= 1'b0;
            state_q <= ST_IDLE;
          end
        endcase
      end
    end
  end

  for (genvar g = 0; g < CMD_MAX; g++) begin : g_cmd
    assign cmd_data_o[8*g +: 8] = cmd_buf_q[g];
  end

  assign sda_oe_o    = oe_q;
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_len_o   = cmd_len_q;
endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned CMD_MAX = 8,
  parameter int unsigned RSP_MAX = 16,
  parameter int unsigned CMD_LW  = 4,
  parameter int unsigned RSP_IW  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s_i,
  input logic              sda_oe_i,
  input logic              cmd_valid_i,
  input logic [CMD_LW-1:0] cmd_len_i,
  input slv_state_e        state_i,
  input logic [6:0]        addr_i,
  input logic              boot_done_i,
  input logic [RSP_IW-1:0] rd_idx_i
);
  // R8
  oe_moves_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> !$past(scl_s_i));

  // R4
  idle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> !sda_oe_i);

  // R7
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> !cmd_valid_i);

  // R6
  frame_len_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> (cmd_len_i <= CMD_LW'(CMD_MAX)));

  // R3
  addr_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_i |=> $stable(addr_i));

  // R10
  read_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_i <= RSP_IW'(RSP_MAX));
endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk #(
  .CMD_MAX(CMD_MAX),
  .RSP_MAX(RSP_MAX),
  .CMD_LW (CMD_LW),
  .RSP_IW (RSP_IW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s_i    (scl_s),
  .sda_oe_i   (sda_oe_o),
  .cmd_valid_i(cmd_valid_o),
  .cmd_len_i  (cmd_len_o),
  .state_i    (state_q),
  .addr_i     (own_addr),
  .boot_done_i(boot_done),
  .rd_idx_i   (rd_idx_q)
);

// File: tb/i2c_cmd_slave_test.sv
module i2c_cmd_slave_test;
  localparam int CMD_MAX = 8;
  localparam int RSP_MAX = 16;
  localparam int Q       = 10;

  typedef struct packed {
    logic [3:0]  n;
    logic [63:0] d;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{4'd1, 64'h0000_0000_0000_005A},
    '{4'd3, 64'h0000_0000_00C3_7E01},
    '{4'd8, 64'h0123_4567_89AB_CDEF},
    '{4'd0, 64'h0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b1;
  logic [8*RSP_MAX-1:0] rsp_data;
  logic sda_oe, cmd_valid, sda_line;
  logic [3:0] cmd_len;
  logic [8*CMD_MAX-1:0] cmd_data;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  logic [3:0]  last_len = '0;
  logic [63:0] last_data = '0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_cmd_slave uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .addr_sel_i (addr_sel),
    .rsp_data_i (rsp_data),
    .cmd_valid_o(cmd_valid),
    .cmd_len_o  (cmd_len),
    .cmd_data_o (cmd_data)
  );

  always @(posedge clk) begin
    if (cmd_valid) begin
      pulses    <= pulses + 1;
      last_len  <= cmd_len;
      last_data <= cmd_data;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
    wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    b = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~ack);
  endtask

  task automatic finish_tb();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_tb();
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int p0;
    for (int k = 0; k < RSP_MAX; k++) rsp_data[8*k +: 8] = 8'(8'hC3 ^ (k * 8'h1D));

    // R12 reset state
    repeat (4) @(negedge clk);
    check("R12 oe in reset", 64'(sda_oe), 64'h0);
    check("R12 valid in reset", 64'(cmd_valid), 64'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 oe after reset", 64'(sda_oe), 64'h0);

    // R2 R5 R7 table of write frames, strap high -> 7'h1B
    for (int v = 0; v < 4; v++) begin
      p0 = pulses;
      bus_start();
      send_byte({7'h1B, 1'b0}, ack);
      check("R2 R3 address ack", 64'(ack), 64'h1);
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        send_byte(VECS[v].d[8*i +: 8], ack);
        check("R5 data ack", 64'(ack), 64'h1);
      end
      bus_stop();
      check("R7 one strobe", 64'(pulses - p0), 64'h1);
      check("R7 frame length", 64'(last_len), 64'(VECS[v].n));
      for (int i = 0; i < int'(VECS[v].n); i++)
        check("R5 frame byte", 64'(last_data[8*i +: 8]), 64'(VECS[v].d[8*i +: 8]));
      check("R1 released after stop", 64'(sda_oe), 64'h0);
    end

    // R6 overflow: ten bytes, last two nacked and dropped
    p0 = pulses;
    bus_start();
    send_byte({7'h1B, 1'b0}, ack);
    for (int i = 0; i < 10; i++) begin
      send_byte(8'(8'h40 + i), ack);
      check("R6 ack per byte", 64'(ack), (i < 8) ? 64'h1 : 64'h0);
    end
    bus_stop();
    check("R6 strobe", 64'(pulses - p0), 64'h1);
    check("R6 length capped", 64'(last_len), 64'd8);
    check("R6 kept bytes", last_data, 64'h4746_4544_4342_4140);

    // R4 mismatch
    p0 = pulses;
    bus_start();
    send_byte({7'h4A, 1'b0}, ack);
    check("R4 no address ack", 64'(ack), 64'h0);
    send_byte(8'h00, ack);
    check("R4 following byte ignored", 64'(ack), 64'h0);
    bus_stop();
    check("R4 R7 no strobe", 64'(pulses - p0), 64'h0);

    // R8 R9 read three bytes, nack last, then clock one more
    p0 = pulses;
    bus_start();
    send_byte({7'h1B, 1'b1}, ack);
    check("R2 read address ack", 64'(ack), 64'h1);
    for (int i = 0; i < 3; i++) begin
      recv_byte(rb, i < 2);
      check("R8 read byte", 64'(rb), 64'(rsp_data[8*i +: 8]));
    end
    recv_byte(rb, 1'b0);
    check("R9 released after nack", 64'(rb), 64'hFF);
    bus_stop();
    check("R7 no strobe on read", 64'(pulses - p0), 64'h0);

    // R10 read cap
    bus_start();
    send_byte({7'h1B, 1'b1}, ack);
    for (int i = 0; i < 17; i++) begin
      recv_byte(rb, 1'b1);
      check("R10 read sequence", 64'(rb), (i < 16) ? 64'(rsp_data[8*i +: 8]) : 64'hFF);
    end
    bus_stop();

    // R11 R1 repeated start drops pending frame
    p0 = pulses;
    bus_start();
    send_byte({7'h1B, 1'b0}, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    bus_start();
    send_byte({7'h1B, 1'b1}, ack);
    check("R1 repeated start address ack", 64'(ack), 64'h1);
    recv_byte(rb, 1'b0);
    check("R1 R8 byte after repeated start", 64'(rb), 64'(rsp_data[7:0]));
    bus_stop();
    check("R11 no strobe", 64'(pulses - p0), 64'h0);

    // R3 strap low at reset, later change ignored
    addr_sel = 1'b0;
    rst_ni = 1'b0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    addr_sel = 1'b1;
    p0 = pulses;
    bus_start();
    send_byte({7'h4A, 1'b0}, ack);
    check("R3 low-strap address ack", 64'(ack), 64'h1);
    send_byte(8'h77, ack);
    bus_stop();
    check("R3 strobe", 64'(pulses - p0), 64'h1);
    check("R3 frame byte", 64'(last_data[7:0]), 64'h77);
    bus_start();
    send_byte({7'h1B, 1'b0}, ack);
    check("R3 strap change ignored", 64'(ack), 64'h0);
    bus_stop();

    finish_tb();
  end
endmodule